// File: doc/BRIEF.md
# Mode-Programmable Phase Accumulator Counter

This block is a single accumulator register (the phase, `PHS_W` bits wide) that advances by a per-step increment in a way chosen by a 5-bit mode code. With one mode it runs as a free-running numerically controlled oscillator. It exposes the top phase bit, and a second output shifted by a quarter period. A family of logic modes turns it into an event or time counter. These modes add the increment only on clocks where a chosen Boolean function of two synchronized pin inputs is true, or on a rising edge of the first pin. A quadrature mode turns it into a position counter for a two-phase encoder. Each cycle it reports whether an add or a subtract event occurred, so that other counters can chain off these strobes.

Software drives a one-cycle command port. The commands load the phase, add to it, subtract from it, clear it, or poll and clear a sticky rollover flag. The phase value is always visible on `rd_data`. A wait-for-rollover handshake returns an acknowledge one cycle after any wrap that occurs while the request is held.

Top module: `phase_accum_ctr`

## Requirements
- R1: After reset the phase is 0, the rollover flag and acknowledge are low, and every output is low. In mode 5'b00000 the phase holds and `nco_out`, `qdr_out`, `add_stb` and `sub_stb` stay low. Software commands still act in this mode.
- R2: In mode 5'b01000 the phase grows by `frq` on every clock, and `nco_out` equals the top phase bit.
- R3: In mode 5'b01000, `qdr_out` equals the XNOR of the two top phase bits. Outside that mode, `nco_out` and `qdr_out` are low.
- R4: `pin_a` and `pin_b` each pass through two synchronizing flops. A level presented before clock edge k first shows on `add_stb` after edge k+1, and it changes the phase at edge k+2.
- R5: In modes 5'b10001 to 5'b11110, `frq` is added on clocks where a condition holds. The condition is the bit of the mode's low four bits indexed by {B,A}, with A and B the synchronized pins. Examples: 10001 is !A&!B, 11000 is A&B, 11010 is A, 10110 is A!=B, 11110 is A|B.
- R6: In mode 5'b10000, `frq` is added on a clock where the synchronized A is 1 and was 0 one clock earlier.
- R7: In mode 5'b11111 the pins form a Gray-coded pair {A,B}. Forward steps are 00->01->11->10->00, and each one adds `frq`. Each step in the reverse order subtracts `frq`. A change of both pins at once is ignored. `sub_stb` is high only in this mode.
- R8: `add_stb` is high in every cycle whose edge performs a condition add or a forward step. `sub_stb` is high in every cycle of a reverse step. The two are never high together, and a software command does not suppress them.
- R9: `cmd_op` codes, acted on when `cmd_valid` is high: 1 loads `cmd_data`, 2 adds `cmd_data`, 3 subtracts `cmd_data`, 4 clears to zero, 5 polls the flag, 0 does nothing. `rd_data` always shows the current phase.
- R10: A load, add, subtract or clear command in the same cycle as an accumulate takes priority. The accumulate of that cycle is dropped.
- R11: During a clear command `rd_data` shows the value from before the clear. From the next cycle it reads 0.
- R12: A carry out of the top bit on any add, or a borrow on any subtract, sets `wrap_flag`. The flag stays set until a poll command. A poll clears it at the next edge unless a new wrap occurs in that same cycle.
- R13: `sync_ack` is high for the cycle after an edge at which a wrap occurred while `sync_req` was high, and low otherwise.
- R14: Mode codes 5'b00001 to 5'b00111 and 5'b01001 to 5'b01111 behave as mode 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 5 | Counting mode code |
| frq | input | PHS_W | Increment added or subtracted per step |
| pin_a | input | 1 | First asynchronous pin input |
| pin_b | input | 1 | Second asynchronous pin input |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code |
| cmd_data | input | PHS_W | Command operand |
| sync_req | input | 1 | Wait-for-rollover request |
| rd_data | output | PHS_W | Current phase value |
| wrap_flag | output | 1 | Sticky rollover flag |
| sync_ack | output | 1 | Rollover acknowledge |
| nco_out | output | 1 | Top phase bit in oscillator mode |
| qdr_out | output | 1 | Quarter-period shifted output |
| add_stb | output | 1 | Add event this cycle |
| sub_stb | output | 1 | Subtract event this cycle |

## Verification
The checker watches several rules on every cycle. It checks the oscillator step, the hold in the off mode, the load and clear results, and the flag's stickiness. It also checks that subtract strobes appear only in encoder mode, that the two strobes are exclusive, and that an acknowledge always follows a request. The truth table of every logic mode, the synchronizer latency, the Gray-code direction decode and the rejection of double changes need the scenarios. The same holds for the drop of an accumulate under a software command and for wrap detection on software arithmetic. Each scenario is compared cycle by cycle with a bench model that restates the conditions as explicit Boolean expressions.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  localparam logic [4:0] MODE_OFF  = 5'b00000;
  localparam logic [4:0] MODE_NCO  = 5'b01000;
  localparam logic [4:0] MODE_EDGE = 5'b10000;
  localparam logic [4:0] MODE_ENC  = 5'b11111;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SET  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_CLR  = 3'd4,
    OP_POLL = 3'd5
  } cmd_op_e;

  // Logic-mode condition: the low four mode bits form a truth table over {b,a}.
  function automatic logic cond_hit(logic [4:0] md, logic a, logic b, logic a_prev);
    if (md == MODE_EDGE) return a & ~a_prev;
    return md[{b, a}];
  endfunction

  // Encoder half-step on pair {a,b}: returns {reverse, forward}.
  function automatic logic [1:0] enc_step(logic [1:0] prev, logic [1:0] cur);
    case ({prev, cur})
      4'b00_01, 4'b01_11, 4'b11_10, 4'b10_00: return 2'b01;
      4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: return 2'b10;
      default:                                 return 2'b00;
    endcase
  endfunction

endpackage

// File: rtl/ctr_pin_sync.sv
module ctr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic synced,
  output logic synced_prev
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], pin};
      prev_q <= sr_q[STAGES-1];
    end
  end

  assign synced      = sr_q[STAGES-1];
  assign synced_prev = prev_q;
endmodule

// File: rtl/ctr_event_decode.sv
module ctr_event_decode
  import ctr_pkg::*;
(
  input  logic [4:0] mode,
  input  logic       a,
  input  logic       b,
  input  logic       a_prev,
  input  logic       b_prev,
  output logic       add_evt,
  output logic       sub_evt
);
  logic       is_logic;
  logic       is_enc;
  logic [1:0] step;

  assign is_enc   = (mode == MODE_ENC);
  assign is_logic = mode[4] & ~is_enc;
  assign step     = enc_step({a_prev, b_prev}, {a, b});

  always_comb begin
    add_evt = 1'b0;
    sub_evt = 1'b0;
    if (is_logic) begin
      add_evt = cond_hit(mode, a, b, a_prev);
    end else if (is_enc) begin
      add_evt = step[0];
      sub_evt = step[1];
    end
  end
endmodule

// File: rtl/ctr_phase_reg.sv
module ctr_phase_reg
  import ctr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_en,
  input  logic         dec_en,
  input  logic [W-1:0] step_val,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] cmd_data,
  output logic [W-1:0] phs,
  output logic         wrap_evt
);
  logic [W-1:0] phs_q;
  logic [W-1:0] phs_d;
  logic [W:0]   ext;
  logic         sw_touch;

  function automatic logic [W:0] add_c(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  function automatic logic [W:0] sub_b(logic [W-1:0] x, logic [W-1:0] y);
    return {1'b0, x} - {1'b0, y};
  endfunction

  assign sw_touch = cmd_valid && (cmd_op == OP_SET || cmd_op == OP_ADD ||
                                  cmd_op == OP_SUB || cmd_op == OP_CLR);

  always_comb begin
    ext      = {1'b0, phs_q};
    wrap_evt = 1'b0;
    if (sw_touch) begin
      case (cmd_op)
        OP_SET:  ext = {1'b0, cmd_data};
        OP_ADD:  ext = add_c(phs_q, cmd_data);
        OP_SUB:  ext = sub_b(phs_q, cmd_data);
        default: ext = '0;
      endcase
      wrap_evt = ext[W] & (cmd_op == OP_ADD || cmd_op == OP_SUB);
    end else if (inc_en) begin
      ext      = add_c(phs_q, step_val);
      wrap_evt = ext[W];
    end else if (dec_en) begin
      ext      = sub_b(phs_q, step_val);
      wrap_evt = ext[W];
    end
    phs_d = ext[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phs_q <= '0;
    else        phs_q <= phs_d;
  end

  assign phs = phs_q;
endmodule

// File: rtl/phase_accum_ctr.sv
module phase_accum_ctr
  import ctr_pkg::*;
#(
  parameter int PHS_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       mode,
  input  logic [PHS_W-1:0] frq,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [PHS_W-1:0] cmd_data,
  input  logic             sync_req,
  output logic [PHS_W-1:0] rd_data,
  output logic             wrap_flag,
  output logic             sync_ack,
  output logic             nco_out,
  output logic             qdr_out,
  output logic             add_stb,
  output logic             sub_stb
);
  localparam int NPINS = 2;
  localparam int TOP   = PHS_W - 1;

  logic [NPINS-1:0] pin_raw, pin_s, pin_p;
  logic             add_evt, sub_evt, nco_mode, wrap_evt, poll_cmd;
  logic [PHS_W-1:0] phs;
  logic             flag_q, ack_q;

  assign pin_raw = {pin_b, pin_a};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    ctr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_raw[g]),
      .synced(pin_s[g]), .synced_prev(pin_p[g])
    );
  end

  ctr_event_decode u_dec (
    .mode(mode), .a(pin_s[0]), .b(pin_s[1]),
    .a_prev(pin_p[0]), .b_prev(pin_p[1]),
    .add_evt(add_evt), .sub_evt(sub_evt)
  );

  assign nco_mode = (mode == MODE_NCO);

  ctr_phase_reg #(.W(PHS_W)) u_phs (
    .clk(clk), .rst_n(rst_n),
    .inc_en(add_evt | nco_mode), .dec_en(sub_evt), .step_val(frq),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .phs(phs), .wrap_evt(wrap_evt)
  );

  assign poll_cmd = cmd_valid && (cmd_op == OP_POLL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      flag_q <= wrap_evt | (flag_q & ~poll_cmd);
      ack_q  <= wrap_evt & sync_req;
    end
  end

  assign rd_data   = phs;
  assign wrap_flag = flag_q;
  assign sync_ack  = ack_q;
  assign nco_out   = nco_mode & phs[TOP];
  assign qdr_out   = nco_mode & ~(phs[TOP] ^ phs[TOP-1]);
  assign add_stb   = add_evt;
  assign sub_stb   = sub_evt;
endmodule

// File: rtl/ctr_checker.sv
module ctr_checker
  import ctr_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   mode,
  input logic [W-1:0] frq,
  input logic         cmd_valid,
  input logic [2:0]   cmd_op,
  input logic [W-1:0] cmd_data,
  input logic         sync_req,
  input logic [W-1:0] rd_data,
  input logic         wrap_flag,
  input logic         sync_ack,
  input logic         add_stb,
  input logic         sub_stb
);
  a_r1_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF && !cmd_valid) |=> (rd_data == $past(rd_data)));

  a_r2_nco_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NCO && !cmd_valid) |=> (rd_data == $past(rd_data) + $past(frq)));

  a_r7_sub_only_enc: assert property (@(posedge clk) disable iff (!rst_n)
    sub_stb |-> (mode == MODE_ENC));

  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_stb && sub_stb));

  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_SET) |=> (rd_data == $past(cmd_data)));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_CLR) |=> (rd_data == '0));

  a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_flag && !(cmd_valid && cmd_op == OP_POLL)) |=> wrap_flag);

  a_r13_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |-> $past(sync_req));
endmodule

bind phase_accum_ctr ctr_checker #(.W(PHS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .frq(frq),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
  .sync_req(sync_req), .rd_data(rd_data), .wrap_flag(wrap_flag),
  .sync_ack(sync_ack), .add_stb(add_stb), .sub_stb(sub_stb)
);

// File: tb/phase_accum_ctr_bench.sv
module phase_accum_ctr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = '0;
  logic [31:0] frq = '0;
  logic        pin_a = 1'b0, pin_b = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_data = '0;
  logic        sync_req = 1'b0;
  logic [31:0] rd_data;
  logic        wrap_flag, sync_ack, nco_out, qdr_out, add_stb, sub_stb;

  always #4 clk = ~clk;

  phase_accum_ctr u_phase_accum_ctr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .frq(frq), .pin_a(pin_a), .pin_b(pin_b),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .sync_req(sync_req),
    .rd_data(rd_data), .wrap_flag(wrap_flag), .sync_ack(sync_ack),
    .nco_out(nco_out), .qdr_out(qdr_out), .add_stb(add_stb), .sub_stb(sub_stb)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // bench model state
  logic        m_s1a = 0, m_s2a = 0, m_pa = 0, m_s1b = 0, m_s2b = 0, m_pb = 0;
  logic [31:0] m_phs = 0;
  logic        m_flag = 0, m_ack = 0;
  logic        walk_a = 0, walk_b = 0;

  task automatic chk(bit ok, string req, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_cond(logic [4:0] md, logic a, logic b, logic pa);
    case (md)
      5'b10000: return a && !pa;
      5'b10001: return !a && !b;
      5'b10010: return a && !b;
      5'b10011: return !b;
      5'b10100: return !a && b;
      5'b10101: return !a;
      5'b10110: return a != b;
      5'b10111: return !a || !b;
      5'b11000: return a && b;
      5'b11001: return a == b;
      5'b11010: return a;
      5'b11011: return a || !b;
      5'b11100: return b;
      5'b11101: return !a || b;
      5'b11110: return a || b;
      default:  return 0;
    endcase
  endfunction

  function automatic int gray_pos(logic a, logic b);
    case ({a, b})
      2'b00: return 0;
      2'b01: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic string tag_of(logic [4:0] md);
    if (md == 5'b11111) return "R7";
    if (md == 5'b10000) return "R6";
    if (md[4]) return "R5";
    if (md == 5'b00000) return "R1";
    return "R14";
  endfunction

  // Drive one cycle after a falling edge, check pre-edge outputs, advance model.
  task automatic step(logic [4:0] md, logic [31:0] fq, logic a, logic b,
                      logic v, logic [2:0] op, logic [31:0] d, logic rq);
    bit e_add, e_sub, wrap, sw, poll;
    int diff;
    logic [31:0] nxt;
    mode = md; frq = fq; pin_a = a; pin_b = b;
    cmd_valid = v; cmd_op = op; cmd_data = d; sync_req = rq;
    #1;
    e_add = 0; e_sub = 0;
    if (md == 5'b11111) begin
      diff = (gray_pos(m_s2a, m_s2b) - gray_pos(m_pa, m_pb) + 4) % 4;
      e_add = (diff == 1);
      e_sub = (diff == 3);
    end else begin
      e_add = m_cond(md, m_s2a, m_s2b, m_pa);
    end
    chk(add_stb == e_add, {tag_of(md), "/R8 add_stb"}, add_stb, e_add);
    chk(sub_stb == e_sub, {tag_of(md), "/R8 sub_stb"}, sub_stb, e_sub);
    chk(rd_data == m_phs, "R9 rd_data", rd_data, m_phs);
    chk(wrap_flag == m_flag, "R12 wrap_flag", wrap_flag, m_flag);
    chk(sync_ack == m_ack, "R13 sync_ack", sync_ack, m_ack);
    chk(nco_out == ((md == 5'b01000) ? m_phs[31] : 1'b0), "R2 nco_out", nco_out, m_phs[31]);
    chk(qdr_out == ((md == 5'b01000) ? (m_phs[31] == m_phs[30]) : 1'b0), "R3 qdr_out",
        qdr_out, m_phs[31] == m_phs[30]);
    // next state
    sw = v && (op >= 3'd1) && (op <= 3'd4);
    poll = v && (op == 3'd5);
    wrap = 0; nxt = m_phs;
    if (sw) begin
      case (op)
        3'd1: nxt = d;
        3'd2: begin nxt = m_phs + d; wrap = (nxt < m_phs); end
        3'd3: begin nxt = m_phs - d; wrap = (d > m_phs); end
        default: nxt = 0;
      endcase
    end else if (md == 5'b01000 || e_add) begin
      nxt = m_phs + fq; wrap = (nxt < m_phs);
    end else if (e_sub) begin
      nxt = m_phs - fq; wrap = (fq > m_phs);
    end
    @(posedge clk);
    m_phs = nxt;
    m_flag = wrap || (m_flag && !poll);
    m_ack = wrap && rq;
    m_pa = m_s2a; m_s2a = m_s1a; m_s1a = a;
    m_pb = m_s2b; m_s2b = m_s1b; m_s1b = b;
    @(negedge clk);
  endtask

  task automatic run_mode(logic [4:0] md, int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] fq, d;
      logic v;
      logic [2:0] op;
      int r;
      fq = (($urandom % 4) == 0) ? (32'hFFFF_FFFF - ($urandom % 64)) : ($urandom % 4096);
      v = (($urandom % 10) == 0);
      op = 3'($urandom % 6);
      d = (($urandom % 3) == 0) ? $urandom : ($urandom % 256);
      if (md == 5'b11111) begin
        r = $urandom % 6;
        case (r)
          0, 1: begin // forward
            case ({walk_a, walk_b})
              2'b00: walk_b = 1;
              2'b01: walk_a = 1;
              2'b11: walk_b = 0;
              default: walk_a = 0;
            endcase
          end
          2, 3: begin // reverse
            case ({walk_a, walk_b})
              2'b00: walk_a = 1;
              2'b10: walk_b = 1;
              2'b11: walk_a = 0;
              default: walk_b = 0;
            endcase
          end
          4: begin walk_a = ~walk_a; walk_b = ~walk_b; end // invalid double
          default: ;
        endcase
      end else begin
        if (($urandom % 3) == 0) walk_a = ~walk_a;
        if (($urandom % 3) == 0) walk_b = ~walk_b;
      end
      step(md, fq, walk_a, walk_b, v, op, d, 1'($urandom % 2));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7713));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == 0, "R1 reset phase", rd_data, 0);
    chk(!wrap_flag && !sync_ack && !nco_out && !qdr_out && !add_stb && !sub_stb,
        "R1 reset outputs", {wrap_flag, sync_ack, nco_out, qdr_out, add_stb, sub_stb}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 synchronizer latency in mode A (11010)
    step(5'b11010, 32'd1, 1, 0, 0, 3'd0, 0, 0);
    chk(add_stb == 0, "R4 stb after one edge", add_stb, 0);
    step(5'b11010, 32'd1, 1, 0, 0, 3'd0, 0, 0);
    chk(add_stb == 1, "R4 stb after two edges", add_stb, 1);
    chk(rd_data == 0, "R4 phase before third edge", rd_data, 0);
    step(5'b11010, 32'd1, 1, 0, 0, 3'd0, 0, 0);
    chk(rd_data == 1, "R4 phase after third edge", rd_data, 1);

    // R2/R3/R12/R13 oscillator wrap with wait request
    step(5'b01000, 32'h10, 1, 0, 1, 3'd1, 32'hFFFF_FFF0, 1);
    chk(rd_data == 32'hFFFF_FFF0, "R10 load beats oscillator step", rd_data, 32'hFFFF_FFF0);
    chk(nco_out == 1 && qdr_out == 1, "R3 both top bits set", {nco_out, qdr_out}, 2'b11);
    step(5'b01000, 32'h10, 1, 0, 0, 3'd0, 0, 1);
    chk(rd_data == 0, "R2 wrap to zero", rd_data, 0);
    chk(wrap_flag == 1, "R12 flag set on wrap", wrap_flag, 1);
    chk(sync_ack == 1, "R13 ack after wrap", sync_ack, 1);
    step(5'b00000, 32'h10, 1, 0, 0, 3'd0, 0, 0);
    chk(wrap_flag == 1 && sync_ack == 0, "R12 flag sticky", {wrap_flag, sync_ack}, 2'b10);
    step(5'b00000, 32'h10, 1, 0, 1, 3'd5, 0, 0);
    chk(wrap_flag == 0, "R12 poll clears", wrap_flag, 0);

    // R10 software add drops accumulate (A held high)
    step(5'b11010, 32'd1, 1, 0, 1, 3'd1, 32'd100, 0);
    step(5'b11010, 32'd1, 1, 0, 1, 3'd2, 32'd5, 0);
    chk(rd_data == 105, "R10 add command priority", rd_data, 105);
    step(5'b11010, 32'd1, 1, 0, 0, 3'd0, 0, 0);
    chk(rd_data == 106, "R10 accumulate resumes", rd_data, 106);
    // R11 clear returns prior value then zero
    chk(rd_data == 106, "R11 value before clear", rd_data, 106);
    step(5'b11010, 32'd1, 1, 0, 1, 3'd4, 0, 0);
    chk(rd_data == 0, "R11 cleared", rd_data, 0);

    // R14 unused mode holds
    step(5'b01100, 32'd9, 0, 1, 1, 3'd1, 32'd7, 0);
    for (int i = 0; i < 6; i++) step(5'b01100, 32'd9, 1'(i % 2), 1'(i / 2 % 2), 0, 3'd0, 0, 0);
    chk(rd_data == 7 && !add_stb && !nco_out, "R14 unused mode holds", rd_data, 7);

    // randomized sweeps across every mode
    run_mode(5'b00000, 120);
    run_mode(5'b01000, 200);
    for (int m = 16; m < 32; m++) run_mode(5'(m), 200);
    run_mode(5'b11111, 600);
    run_mode(5'b00101, 100);
    run_mode(5'b01011, 100);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule